// File: doc/BRIEF.md
# Clock synthesizer control unit

This unit is the digital control half of a frequency synthesizer. Software writes a 16-bit control word through a simple write port. The word holds a feedback prescaler bit, an output doubler bit, a six-bit feedback modulus, an E-clock rate select and two low-power-stop options. The unit turns the frequency fields into a system-clock ratio relative to the reference. It also models the loop's settling time with a relock counter that runs on the reference clock. No analog loop is modelled.

A state machine tracks the loop in three states. **BOOT** is entered at reset, counts out the first settling time and holds the chip in reset. **LOCKED** means the loop has settled. **RELOCK** covers a resettling period that follows a change in the loop. The transitions are:
- BOOT→LOCKED when the count expires.
- LOCKED→RELOCK on a write that changes a feedback field.
- RELOCK→LOCKED when the count expires.
- BOOT→BOOT and RELOCK→RELOCK (counter reloaded) on any write made while the counter runs.

A free-running divider produces the slow E clock. A small selector picks the core clock source, the loop enable and the clock output enable while the chip is in stop.

Top module: `clksyn_ctrl`

## Requirements
- R1: The control word layout is: bit 15 feedback prescaler select (W), bit 14 output doubler (X), bits 13:8 feedback modulus (Y), bit 7 E-clock slow select, bit 1 stop core-clock select, bit 0 stop output enable. Reading `rd_data` returns these fields, with the lock flag on bit 3 and zeros on bits 6:4 and bit 2.
- R2: `ratio` equals (Y+1) shifted left by 2·W+X. It takes the new value in the cycle after the write.
- R3: A write that changes W or Y while LOCKED drives the lock flag low for exactly RELOCK_CYC reference cycles after the write edge.
- R4: A write that changes none of W and Y (for example only X) while LOCKED leaves the lock flag high.
- R5: Any write made during RELOCK restarts the full RELOCK_CYC count from that write. This includes a write in the last counting cycle.
- R6: `chip_rst_n` is low from reset until RELOCK_CYC cycles after reset release, then high for good.
- R7: The lock flag reads 0 until the first write after reset, even once the loop has settled.
- R8: `e_clk` has a period of 8 reference cycles when the slow select is 0 and 16 when it is 1, with a 50% duty cycle.
- R9: A change of the slow select takes effect only at an E-clock period boundary, so every high and low phase is exactly half of either period.
- R10: With `stop_req` high, `core_from_vco` and `vco_en` follow the stop core-clock select. With the select clear the loop is off and the lock flag (after the first write) reads 1. With `stop_req` low both are 1.
- R11: With `stop_req` high, `clkout_en` equals stop output enable AND `ext_clk_off`. With `stop_req` low, `clkout_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Control word readback with lock flag |
| stop_req | input | 1 | Low-power stop active |
| ext_clk_off | input | 1 | External clock output control for stop |
| ratio | output | 10 | System clock to reference ratio |
| lock | output | 1 | Lock status flag |
| chip_rst_n | output | 1 | Chip reset release, low until first lock |
| e_clk | output | 1 | Slow E clock |
| core_from_vco | output | 1 | Core clock source: 1 loop, 0 crystal |
| vco_en | output | 1 | Loop oscillator enable |
| clkout_en | output | 1 | Clock output pin enable |

## Verification
Two events can land in the same cycle: a write that reloads the relock counter, and the counter's own expiry from 1 to 0. The bench issues a write exactly in the last counting cycle of a relock. It expects the reload to win, so the lock flag stays low for a further full RELOCK_CYC cycles and never shows a one-cycle high. A second coincidence is a slow-select change next to an E-clock wrap. The bench toggles the select at arbitrary points, measures every complete high and low phase around the switch, and accepts only phases of 4 or 8 cycles.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
    localparam int Y_W = 6;

    typedef enum logic [1:0] {
        S_BOOT   = 2'd0,
        S_LOCKED = 2'd1,
        S_RELOCK = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic           w_fast;
        logic           x_dbl;
        logic [Y_W-1:0] y_mod;
        logic           e_slow;
        logic           stop_vco;
        logic           stop_out;
    } syn_cfg_t;
endpackage

// File: rtl/clksyn_relock_fsm.sv
module clksyn_relock_fsm
    import clksyn_pkg::*;
#(
    parameter int RELOCK_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic fb_change,
    output logic settled,
    output logic boot_done
);
    localparam int CW = $clog2(RELOCK_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(RELOCK_CYC);

    lock_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_BOOT, S_RELOCK: begin
                if (wr_en) begin
                    cnt_d = RELOAD;
                end else if (cnt_q <= CW'(1)) begin
                    cnt_d   = '0;
                    state_d = S_LOCKED;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            S_LOCKED: begin
                if (wr_en && fb_change) begin
                    cnt_d   = RELOAD;
                    state_d = S_RELOCK;
                end
            end
            default: begin
                cnt_d   = RELOAD;
                state_d = S_BOOT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_BOOT;
            cnt_q   <= RELOAD;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        settled   = (state_q == S_LOCKED);
        boot_done = (state_q != S_BOOT);
    end

    p_start_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOCKED && wr_en && fb_change) |=> (state_q == S_RELOCK && cnt_q == RELOAD));
    p_hold_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOCKED && !(wr_en && fb_change)) |=> (state_q == S_LOCKED));
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RELOCK && wr_en) |=> (state_q == S_RELOCK && cnt_q == RELOAD));
    p_boot_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_BOOT) |=> (state_q != S_BOOT));
endmodule

// File: rtl/clksyn_eclk_div.sv
module clksyn_eclk_div #(
    parameter int SLOW_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_slow,
    output logic e_clk
);
    localparam int CW = $clog2(SLOW_DIV);
    localparam logic [CW-1:0] LAST_SLOW = CW'(SLOW_DIV - 1);
    localparam logic [CW-1:0] LAST_FAST = CW'(SLOW_DIV / 2 - 1);

    logic [CW-1:0] cnt_q;
    logic          sel_q;
    logic          wrap;

    assign wrap  = sel_q ? (cnt_q == LAST_SLOW) : (cnt_q == LAST_FAST);
    assign e_clk = sel_q ? cnt_q[CW-1] : cnt_q[CW-2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            sel_q <= sel_slow;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    p_switch_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != $past(sel_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/clksyn_stop_sel.sv
module clksyn_stop_sel (
    input  logic stop_req,
    input  logic ext_clk_off,
    input  logic stop_vco,
    input  logic stop_out,
    output logic core_from_vco,
    output logic vco_en,
    output logic clkout_en
);
    always_comb begin
        if (stop_req) begin
            core_from_vco = stop_vco;
            vco_en        = stop_vco;
            clkout_en     = stop_out & ext_clk_off;
        end else begin
            core_from_vco = 1'b1;
            vco_en        = 1'b1;
            clkout_en     = 1'b1;
        end
    end
endmodule

// File: rtl/clksyn_ctrl.sv
module clksyn_ctrl
    import clksyn_pkg::*;
#(
    parameter int RELOCK_CYC = 64,
    parameter int SLOW_DIV   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        stop_req,
    input  logic        ext_clk_off,
    output logic [9:0]  ratio,
    output logic        lock,
    output logic        chip_rst_n,
    output logic        e_clk,
    output logic        core_from_vco,
    output logic        vco_en,
    output logic        clkout_en
);
    localparam int RATIO_W = Y_W + 4;

    syn_cfg_t cfg_q, cfg_new;
    logic     written_q;
    logic     fb_change;
    logic     settled;
    logic     unused_rsvd;
    logic [RATIO_W-1:0] base;

    assign cfg_new = '{w_fast: wr_data[15], x_dbl: wr_data[14], y_mod: wr_data[13:8],
                       e_slow: wr_data[7], stop_vco: wr_data[1], stop_out: wr_data[0]};
    assign unused_rsvd = ^wr_data[6:2];
    assign fb_change = (cfg_new.w_fast != cfg_q.w_fast) || (cfg_new.y_mod != cfg_q.y_mod);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            written_q <= 1'b0;
        end else if (wr_en) begin
            cfg_q     <= cfg_new;
            written_q <= 1'b1;
        end
    end

    clksyn_relock_fsm #(.RELOCK_CYC(RELOCK_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .fb_change (fb_change),
        .settled   (settled),
        .boot_done (chip_rst_n)
    );

    clksyn_eclk_div #(.SLOW_DIV(SLOW_DIV)) u_ediv (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_slow (cfg_q.e_slow),
        .e_clk    (e_clk)
    );

    clksyn_stop_sel u_stop (
        .stop_req      (stop_req),
        .ext_clk_off   (ext_clk_off),
        .stop_vco      (cfg_q.stop_vco),
        .stop_out      (cfg_q.stop_out),
        .core_from_vco (core_from_vco),
        .vco_en        (vco_en),
        .clkout_en     (clkout_en)
    );

    assign base  = RATIO_W'(cfg_q.y_mod) + RATIO_W'(1);
    assign ratio = base << {cfg_q.w_fast, cfg_q.x_dbl};
    assign lock  = written_q & (settled | ~vco_en);

    assign rd_data = {cfg_q.w_fast, cfg_q.x_dbl, cfg_q.y_mod, cfg_q.e_slow,
                      3'b000, lock, 1'b0, cfg_q.stop_vco, cfg_q.stop_out};

    p_flag_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!written_q && !wr_en) |=> !lock);
    p_ratio_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ratio >= RATIO_W'(cfg_q.y_mod)));
endmodule

// File: tb/clksyn_ctrl_tb_top.sv
module clksyn_ctrl_tb_top;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        stop_req = 1'b0;
    logic        ext_clk_off = 1'b0;
    logic [15:0] rd_data;
    logic [9:0]  ratio;
    logic        lock, chip_rst_n, e_clk, core_from_vco, vco_en, clkout_en;

    int checks = 0;
    int errors = 0;
    logic [15:0] cur = '0;

    always #5 clk = ~clk;

    clksyn_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .stop_req(stop_req), .ext_clk_off(ext_clk_off), .ratio(ratio), .lock(lock),
        .chip_rst_n(chip_rst_n), .e_clk(e_clk), .core_from_vco(core_from_vco),
        .vco_en(vco_en), .clkout_en(clkout_en)
    );

    function automatic logic [9:0] exp_ratio(logic [15:0] d);
        return (10'(d[13:8]) + 10'd1) << {d[15], d[14]};
    endfunction

    function automatic logic [15:0] exp_rd(logic [15:0] d, logic lk);
        return (d & 16'hFF83) | {12'd0, lk, 3'd0};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [15:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        cur = d;
    endtask

    task automatic phases(int span, output int bad);
        int len = 0;
        logic prev = e_clk;
        logic started = 1'b0;
        bad = 0;
        for (int i = 0; i < span; i++) begin
            @(negedge clk);
            if (e_clk != prev) begin
                if (started && len != 4 && len != 8) bad++;
                started = 1'b1;
                len = 1;
            end else begin
                len++;
            end
            prev = e_clk;
        end
    endtask

    task automatic period(output int per, output int hi);
        while (e_clk) @(negedge clk);
        while (!e_clk) @(negedge clk);
        per = 0;
        hi = 0;
        while (e_clk) begin hi++; per++; @(negedge clk); end
        while (!e_clk) begin per++; @(negedge clk); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int bad, per, hi;
        int seed;
        seed = $urandom(32'h5EED);
        cyc(2);
        chk("R6 reset chip_rst_n", chip_rst_n, 0);
        chk("R7 reset lock", lock, 0);
        chk("R2 reset ratio", ratio, 1);
        chk("R1 reset readback", rd_data, 0);
        rst_n = 1'b1;
        cyc(N - 1);
        chk("R6 still in reset", chip_rst_n, 0);
        cyc(1);
        chk("R6 released", chip_rst_n, 1);
        chk("R7 no write yet", lock, 0);
        cyc(10);
        chk("R7 settled, unwritten", lock, 0);

        wr(16'h4000);
        chk("R4 X only keeps lock", lock, 1);
        chk("R2 ratio X", ratio, exp_ratio(cur));
        chk("R1 readback X", rd_data, exp_rd(cur, 1'b1));

        wr(16'h0500);
        chk("R3 relock starts", lock, 0);
        chk("R2 ratio Y", ratio, exp_ratio(cur));
        cyc(N - 1);
        chk("R3 low for full count", lock, 0);
        cyc(1);
        chk("R3 relocked", lock, 1);

        wr(16'h8500);
        cyc(30);
        wr(16'h8580);
        cyc(N - 1);
        chk("R5 restart mid relock", lock, 0);
        cyc(1);
        chk("R5 relock after restart", lock, 1);

        wr(16'h0300);
        cyc(N - 1);
        wr(16'h0300);
        chk("R5 write at expiry", lock, 0);
        cyc(N - 1);
        chk("R5 expiry restart low", lock, 0);
        cyc(1);
        chk("R5 expiry restart lock", lock, 1);
        chk("R6 stays released", chip_rst_n, 1);

        for (int k = 0; k < 20; k++) begin
            logic [15:0] d;
            logic exp_lk;
            d = 16'($urandom());
            exp_lk = (d[15] == cur[15]) && (d[13:8] == cur[13:8]);
            wr(d);
            chk(exp_lk ? "R4 random lock" : "R3 random lock", lock, exp_lk);
            chk("R2 random ratio", ratio, exp_ratio(d));
            chk("R1 random readback", rd_data, exp_rd(d, exp_lk));
            cyc(N + 4);
        end

        wr(cur & 16'hFF7F);
        cyc(40);
        period(per, hi);
        chk("R8 fast period", per, 8);
        chk("R8 fast high", hi, 4);
        wr(cur | 16'h0080);
        cyc(40);
        period(per, hi);
        chk("R8 slow period", per, 16);
        chk("R8 slow high", hi, 8);

        for (int k = 0; k < 6; k++) begin
            cyc(($urandom() % 13) + 1);
            wr(cur ^ 16'h0080);
            phases(60, bad);
            chk("R9 no runt phase", bad, 0);
        end

        cyc(N + 4);
        chk("R10 run core src", core_from_vco, 1);
        chk("R11 run clkout", clkout_en, 1);
        wr(16'h2A00);
        stop_req = 1'b1;
        ext_clk_off = 1'b1;
        cyc(1);
        chk("R10 stop vco off", vco_en, 0);
        chk("R10 stop crystal core", core_from_vco, 0);
        chk("R10 lock when vco off", lock, 1);
        chk("R11 output held", clkout_en, 0);
        wr(16'h2A03);
        chk("R10 stop vco kept", vco_en, 1);
        chk("R10 stop vco core", core_from_vco, 1);
        chk("R11 output follows", clkout_en, 1);
        ext_clk_off = 1'b0;
        cyc(1);
        chk("R11 output needs ext ctrl", clkout_en, 0);
        stop_req = 1'b0;
        cyc(1);
        chk("R11 run clkout again", clkout_en, 1);
        chk("R10 run vco on", vco_en, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule